// File: doc/BRIEF.md
# Conflict-Free Bank Address Generator for a Parallel Radix-2 FFT

This block sequences a radix-2 FFT whose flow graph has the same shape in every stage, and which runs K butterfly units side by side over 2K single-ported memory banks. After a start strobe it steps through log2(N) stages. Each stage takes N/(2K) read cycles, one group of K butterflies per cycle. The block drives one word address per bank and one swap select per steering multiplexer, so that the 2K operands of a group come from 2K different banks. The 2K results of that group go back to 2K different banks after a fixed butterfly latency.

Butterfly j of a stage takes points j and j+N/2 and produces points 2j and 2j+1. Point p lives in bank `{p[LOGK] ^ p[LOGN-1], p[LOGK-1:0]}` at word `p[LOGN-1:LOGK+1]`, where LOGN = log2(N) and LOGK = log2(K). With this placement, every bank address is a fixed rewiring of the group counter. The only selects are one bit per steering multiplexer. The butterfly arithmetic, the twiddle factors and the memory arrays sit outside this block.

Top module: `fft_agen`

## Requirements
- R1: While reset is applied, and afterwards until a start strobe is seen, `bfly_vld`, `wr_vld` and `done` are low.
- R2: In read cycle g of a stage, operand slot s (slots 0..K-1 carry operand A of butterfly s, slots K..2K-1 carry operand B of butterfly s-K) is fed from bank s when `rd_swap[s]` is 0 and from bank s^K when it is 1. The word read there is `rd_addr[bank*AW +: AW]`. Decoded through the placement rule, it is point gK+s for A and point gK+(s-K)+N/2 for B.
- R3: In every read cycle, the 2K banks selected by the 2K operand slots are all distinct.
- R4: In write cycle g, bank b takes result (`wr_swap[b]` ? b^K : b), where result 2i is the first output and result 2i+1 the second output of butterfly i. The word written is `wr_addr[b*AW +: AW]`. Decoded through the placement rule, result r lands at point 2gK+r, and the 2K target banks are distinct.
- R5: `wr_vld` for a group rises exactly LAT cycles after `bfly_vld` for the same group.
- R6: Within a stage, groups 0..N/(2K)-1 are read on consecutive cycles, with `stage` holding the stage number 0..log2(N)-1. The first read of the next stage comes one cycle after the last write of the current stage.
- R7: `done` is high for exactly one cycle, the cycle after the last write of the final stage. The block is idle afterwards.
- R8: A start strobe while a transform is running has no effect on the address sequence.
- R9: Within each stage, every point index is read exactly once and written exactly once.
- R10: The first read cycle (group 0, stage 0) follows the accepted start strobe by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a transform; only sampled while idle |
| bfly_vld | output | 1 | Read addresses valid, one butterfly group issues |
| stage | output | $clog2($clog2(N)+1) | Stage of the group being read |
| rd_addr | output | 2K*AW | Read word address per bank, bank b at [b*AW +: AW] |
| rd_swap | output | 2K | Read steering select per operand slot |
| wr_vld | output | 1 | Write addresses valid, one result group retires |
| wr_addr | output | 2K*AW | Write word address per bank |
| wr_swap | output | 2K | Write steering select per bank |
| done | output | 1 | One-cycle end-of-transform pulse |

AW is log2(N/(2K)).

## Verification
The bench builds two copies side by side. The first uses N=32, K=2 and LAT=3. With eight groups per stage, the read swap toggles every cycle while the write swap flips only halfway through the stage, and a multi-cycle drain separates stages. The second uses N=16, K=4 and LAT=1. This is the densest legal case (2K = N/2), with one-bit bank addresses and only two groups per stage, and the shortest possible gap between a stage's last write and the next stage's first read.

// File: rtl/fft_agen_pkg.sv
package fft_agen_pkg;

  typedef enum logic [1:0] {
    AG_IDLE  = 2'd0,
    AG_READ  = 2'd1,
    AG_DRAIN = 2'd2
  } ag_state_e;

  typedef enum logic {
    SIDE_RD = 1'b0,
    SIDE_WR = 1'b1
  } ag_side_e;

endpackage

// File: rtl/fft_agen_rstsync.sv
module fft_agen_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/fft_agen_ctrl.sv
module fft_agen_ctrl
  import fft_agen_pkg::*;
#(
  parameter  int N   = 64,
  parameter  int K   = 4,
  parameter  int LAT = 2,
  localparam int GW  = $clog2(N / (2 * K)),
  localparam int SW  = $clog2($clog2(N) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          rd_vld,
  output logic [GW-1:0] rd_grp,
  output logic [SW-1:0] stage,
  output logic          busy,
  output logic          done
);

  localparam int LOGN  = $clog2(N);
  localparam int DEPTH = N / (2 * K);
  localparam int DCW   = $clog2(LAT + 1);
  localparam logic [GW-1:0]  LASTG = GW'(DEPTH - 1);
  localparam logic [DCW-1:0] LASTD = DCW'(LAT - 1);
  localparam logic [SW-1:0]  LASTS = SW'(LOGN - 1);

  ag_state_e      state_q, state_n;
  logic [GW-1:0]  grp_q, grp_n;
  logic [SW-1:0]  stage_q, stage_n;
  logic [DCW-1:0] dcnt_q, dcnt_n;
  logic           done_q, done_n;
  logic           seq_en;

  // next-state process
  always_comb begin
    state_n = state_q;
    grp_n   = grp_q;
    stage_n = stage_q;
    dcnt_n  = dcnt_q;
    done_n  = 1'b0;
    unique case (state_q)
      AG_IDLE: begin
        if (start) begin
          state_n = AG_READ;
          grp_n   = '0;
          stage_n = '0;
        end
      end
      AG_READ: begin
        if (grp_q == LASTG) begin
          state_n = AG_DRAIN;
          dcnt_n  = '0;
        end else begin
          grp_n = grp_q + 1'b1;
        end
      end
      AG_DRAIN: begin
        if (dcnt_q == LASTD) begin
          if (stage_q == LASTS) begin
            state_n = AG_IDLE;
            done_n  = 1'b1;
          end else begin
            state_n = AG_READ;
            grp_n   = '0;
            stage_n = stage_q + 1'b1;
          end
        end else begin
          dcnt_n = dcnt_q + 1'b1;
        end
      end
      default: state_n = AG_IDLE;
    endcase
  end

  assign seq_en = (state_q != AG_IDLE) || start;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= AG_IDLE;
      grp_q   <= '0;
      stage_q <= '0;
      dcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      if (seq_en) begin
        state_q <= state_n;
        grp_q   <= grp_n;
        stage_q <= stage_n;
        dcnt_q  <= dcnt_n;
      end
    end
  end

  assign rd_vld = (state_q == AG_READ);
  assign rd_grp = grp_q;
  assign stage  = stage_q;
  assign busy   = (state_q != AG_IDLE);
  assign done   = done_q;

  AST_GRP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == AG_READ && grp_q != LASTG) |=> (state_q == AG_READ && grp_q == $past(grp_q) + 1'b1)); // R6

  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != AG_IDLE) |-> (stage_q <= LASTS)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == AG_READ && grp_q != LASTG && start) |=> (grp_q == $past(grp_q) + 1'b1)); // R8

endmodule

// File: rtl/fft_agen_pipe.sv
module fft_agen_pipe #(
  parameter int W   = 3,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);

  logic         vld_q [LAT];
  logic [W-1:0] dat_q [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_tap
    logic         src_vld;
    logic [W-1:0] src_dat;

    if (i == 0) begin : g_head
      assign src_vld = in_vld;
      assign src_dat = in_dat;
    end else begin : g_body
      assign src_vld = vld_q[i-1];
      assign src_dat = dat_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[i] <= 1'b0;
      else        vld_q[i] <= src_vld;
    end

    // data only moves with a valid beat
    always_ff @(posedge clk) begin
      if (src_vld) dat_q[i] <= src_dat;
    end
  end

  assign out_vld = vld_q[LAT-1];
  assign out_dat = dat_q[LAT-1];

endmodule

// File: rtl/fft_agen_xbar.sv
module fft_agen_xbar
  import fft_agen_pkg::*;
#(
  parameter int       K    = 4,
  parameter int       GW   = 3,
  parameter ag_side_e SIDE = SIDE_RD
) (
  input  logic [GW-1:0]       grp,
  output logic [2*K*GW-1:0]   addr,
  output logic [2*K-1:0]      swap
);

  localparam int NB = 2 * K;

  if (SIDE == SIDE_RD) begin : g_rd
    // lower half of banks holds A operands on even groups, B on odd groups
    logic [GW-1:0] a_lo;
    logic [GW-1:0] a_hi;

    always_comb begin
      a_lo         = grp >> 1;
      a_lo[GW-1]   = grp[0];
      a_hi         = a_lo;
      a_hi[GW-1]   = ~grp[0];
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
      if (b < K) begin : g_lo
        assign addr[b*GW +: GW] = a_lo;
      end else begin : g_hi
        assign addr[b*GW +: GW] = a_hi;
      end
      assign swap[b] = grp[0];
    end
  end else begin : g_wr
    // results of one group form an aligned run; halves trade places in the upper half of the buffer
    for (genvar b = 0; b < NB; b++) begin : g_bank
      assign addr[b*GW +: GW] = grp;
      assign swap[b]          = grp[GW-1];
    end
  end

endmodule

// File: rtl/fft_agen.sv
module fft_agen
  import fft_agen_pkg::*;
#(
  parameter  int N   = 64,
  parameter  int K   = 4,
  parameter  int LAT = 2,
  localparam int NB  = 2 * K,
  localparam int AW  = $clog2(N / (2 * K)),
  localparam int SW  = $clog2($clog2(N) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             bfly_vld,
  output logic [SW-1:0]    stage,
  output logic [NB*AW-1:0] rd_addr,
  output logic [NB-1:0]    rd_swap,
  output logic             wr_vld,
  output logic [NB*AW-1:0] wr_addr,
  output logic [NB-1:0]    wr_swap,
  output logic             done
);

  logic          rst_s_n;
  logic          rd_vld;
  logic [AW-1:0] rd_grp;
  logic [AW-1:0] wr_grp;
  logic          busy;

  fft_agen_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  fft_agen_ctrl #(.N(N), .K(K), .LAT(LAT)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .start  (start),
    .rd_vld (rd_vld),
    .rd_grp (rd_grp),
    .stage  (stage),
    .busy   (busy),
    .done   (done)
  );

  fft_agen_xbar #(.K(K), .GW(AW), .SIDE(SIDE_RD)) u_rd_map (
    .grp  (rd_grp),
    .addr (rd_addr),
    .swap (rd_swap)
  );

  fft_agen_pipe #(.W(AW), .LAT(LAT)) u_lag (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .in_vld  (rd_vld),
    .in_dat  (rd_grp),
    .out_vld (wr_vld),
    .out_dat (wr_grp)
  );

  fft_agen_xbar #(.K(K), .GW(AW), .SIDE(SIDE_WR)) u_wr_map (
    .grp  (wr_grp),
    .addr (wr_addr),
    .swap (wr_swap)
  );

  assign bfly_vld = rd_vld;

  AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_s_n)
    (start && !busy) |=> (bfly_vld && stage == '0)); // R10

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> ($past(wr_vld) && !wr_vld && !bfly_vld)); // R7

  AST_STAGE_GAP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bfly_vld && !$past(bfly_vld)) |-> !wr_vld); // R6

endmodule

// File: tb/fft_agen_tb_top.sv
`timescale 1ns/1ps

module fft_agen_tb_unit #(
  parameter int N   = 32,
  parameter int K   = 2,
  parameter int LAT = 3
) (
  input  logic clk,
  output logic fin,
  output int   n_chk,
  output int   n_err
);

  localparam int LOGN = $clog2(N);
  localparam int LOGK = $clog2(K);
  localparam int NB   = 2 * K;
  localparam int D    = N / NB;
  localparam int AW   = $clog2(D);
  localparam int SW   = $clog2(LOGN + 1);
  localparam int PER  = D + LAT;

  typedef struct {
    int cyc;
    int stg;
    int grp;
  } item_t;

  logic             rst_n;
  logic             start;
  logic             bv, wv, dn;
  logic [SW-1:0]    stg;
  logic [NB*AW-1:0] rda, wra;
  logic [NB-1:0]    rds, wrs;

  item_t rdq[$];
  item_t wrq[$];
  int    cyc = 0;
  int    exp_done = -1;
  int    done_cnt = 0;
  int    rd_cnt [LOGN][N];
  int    wr_cnt [LOGN][N];

  fft_agen #(.N(N), .K(K), .LAT(LAT)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bfly_vld (bv),
    .stage    (stg),
    .rd_addr  (rda),
    .rd_swap  (rds),
    .wr_vld   (wv),
    .wr_addr  (wra),
    .wr_swap  (wrs),
    .done     (dn)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s N=%0d K=%0d %s: actual %0d expected %0d", req, N, K, what, act, exp);
    end
  endtask

  // point index from bank number and word address, per the placement rule
  function automatic int pt_of(input int bank, input int a);
    int par;
    par = ((bank >> LOGK) ^ (a >> (AW - 1))) & 1;
    return (a << (LOGK + 1)) | (par << LOGK) | (bank & (K - 1));
  endfunction

  // monitor: pops expected groups as the design issues them
  always @(negedge clk) begin
    if (rst_n) begin
      if (bv) begin
        if (rdq.size() == 0) begin
          chk(1'b0, "R8", "read with no transform pending", cyc, -1);
        end else begin
          item_t it;
          int    mask;
          it   = rdq.pop_front();
          mask = 0;
          chk(cyc == it.cyc, "R6", "read cycle", cyc, it.cyc);
          chk(int'(stg) == it.stg, "R6", "stage index", int'(stg), it.stg);
          for (int s = 0; s < NB; s++) begin
            int bank, a, p, e;
            bank = rds[s] ? (s ^ K) : s;
            a    = rda[bank*AW +: AW];
            p    = pt_of(bank, a);
            e    = (s < K) ? (it.grp * K + s) : (it.grp * K + (s - K) + N / 2);
            mask = mask | (1 << bank);
            chk(p == e, "R2", "read point", p, e);
            if (p >= 0 && p < N) rd_cnt[it.stg][p]++;
          end
          chk(mask == (1 << NB) - 1, "R3", "read bank set", mask, (1 << NB) - 1);
        end
      end
      if (wv) begin
        if (wrq.size() == 0) begin
          chk(1'b0, "R5", "write with no group pending", cyc, -1);
        end else begin
          item_t it;
          int    mask;
          it   = wrq.pop_front();
          mask = 0;
          chk(cyc == it.cyc, "R5", "write cycle", cyc, it.cyc);
          for (int r = 0; r < NB; r++) begin
            int bank, a, p, e;
            bank = wrs[r] ? (r ^ K) : r;
            a    = wra[bank*AW +: AW];
            p    = pt_of(bank, a);
            e    = 2 * K * it.grp + r;
            mask = mask | (1 << bank);
            chk(p == e, "R4", "write point", p, e);
            if (p >= 0 && p < N) wr_cnt[it.stg][p]++;
          end
          chk(mask == (1 << NB) - 1, "R4", "write bank set", mask, (1 << NB) - 1);
        end
      end
      if (dn) begin
        done_cnt++;
        chk(cyc == exp_done, "R7", "done cycle", cyc, exp_done);
      end
    end
  end

  // driver: pushes the whole expected schedule, then strobes start
  task automatic run(input bit poke);
    int s0;
    for (int st = 0; st < LOGN; st++)
      for (int p = 0; p < N; p++) begin
        rd_cnt[st][p] = 0;
        wr_cnt[st][p] = 0;
      end
    s0 = cyc + 1;
    for (int st = 0; st < LOGN; st++)
      for (int g = 0; g < D; g++) begin
        item_t it;
        it.cyc = s0 + st * PER + g;
        it.stg = st;
        it.grp = g;
        rdq.push_back(it); // R10: group 0 of stage 0 at s0
        it.cyc = it.cyc + LAT;
        wrq.push_back(it);
      end
    exp_done = s0 + LOGN * PER;
    done_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; // R8: strobe while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (cyc < exp_done + 3) @(negedge clk);
    chk(done_cnt == 1, "R7", "done pulses", done_cnt, 1);
    chk(!bv && !wv, "R7", "idle after done", int'(bv) + int'(wv), 0);
    chk(rdq.size() == 0, "R6", "reads left over", rdq.size(), 0);
    chk(wrq.size() == 0, "R5", "writes left over", wrq.size(), 0);
    for (int st = 0; st < LOGN; st++) begin
      int bad;
      bad = 0;
      for (int p = 0; p < N; p++)
        if (rd_cnt[st][p] != 1 || wr_cnt[st][p] != 1) bad++;
      chk(bad == 0, "R9", "points not touched once in stage", bad, 0);
    end
  endtask

  initial begin
    fin   = 1'b0;
    n_chk = 0;
    n_err = 0;
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bv && !wv && !dn, "R1", "outputs in reset", int'(bv) + int'(wv) + int'(dn), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!bv && !wv && !dn, "R1", "outputs idle before start", int'(bv) + int'(wv) + int'(dn), 0);
    run(1'b0);
    run(1'b1);
    fin = 1'b1;
  end

endmodule

module fft_agen_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic fa, fb;
  int   ca, ea, cb, eb;

  fft_agen_tb_unit #(.N(32), .K(2), .LAT(3)) u_a (
    .clk   (clk),
    .fin   (fa),
    .n_chk (ca),
    .n_err (ea)
  );

  fft_agen_tb_unit #(.N(16), .K(4), .LAT(1)) u_b (
    .clk   (clk),
    .fin   (fb),
    .n_chk (cb),
    .n_err (eb)
  );

  initial begin
    int wd;
    int wd_fail;
    wd = 0;
    wd_fail = 0;
    @(negedge clk);
    while (!(fa && fb) && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    if (!(fa && fb)) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
    end
    $display("CHECKS %0d ERRORS %0d", ca + cb + wd_fail, ea + eb + wd_fail);
    $finish;
  end

endmodule